// File: doc/BRIEF.md
# Byte FIFO Pair with Level Interrupts

This block holds the byte queues of a serial controller. One queue carries received bytes from the serial engine to the processor; the other carries bytes the processor writes out towards the serial engine. Each queue reports how many bytes it holds, and the processor can empty either queue at once with a clear pulse.

The block raises interrupts when a queue level crosses a programmable trigger level. The receive side raises its interrupt when enough bytes are waiting. The transmit side raises its interrupt when few enough bytes remain. Two sticky flags record that the engine has finished sending or receiving a frame. Every source has its own enable, and one combined line goes to the interrupt controller. The block also keeps a running count of received bytes, which only a receive clear resets.

Top module: `byte_fifo_irq`

## Requirements
- R1: After reset both counts are 0, both overflow flags are 0, `rx_len` is 0 and both done flags are 0. The level bits follow the trigger levels from the first cycle.
- R2: Each queue returns bytes in the order they were accepted. Each count rises by one per accepted push and falls by one per accepted pop. `fifo_cnt[3:0]` is the receive count and `fifo_cnt[7:4]` is the transmit count.
- R3: A push into a full queue (8 entries) without a pop in the same cycle is dropped, and the count stays 8. It sets that queue's sticky overflow flag: `ovf[0]` for receive, `ovf[1]` for transmit.
- R4: A pop from an empty queue leaves the count at 0, and the popped data reads as 0.
- R5: `irq_stat[3]` is 1 while the receive count is greater than or equal to `trig_lvl[3:0]`.
- R6: `irq_stat[1]` is 1 while the transmit count is less than or equal to `trig_lvl[7:4]`.
- R7: A done strobe sets its sticky flag: `eng_tx_done` sets `irq_stat[0]` and `eng_rx_done` sets `irq_stat[2]`. A flag is cleared by a 1 on the matching bit of `stat_w1c`. If a strobe and a clear arrive in the same cycle, the strobe wins.
- R8: `irq` is 1 exactly when some `irq_stat` bit is 1 and the `irq_en` bit at the same position is 1.
- R9: A clear pulse empties its queue on the next edge and resets that queue's overflow flag. `rx_clr` also resets `rx_len`. A clear takes priority over a push in the same cycle.
- R10: `rx_len` counts every byte accepted into the receive queue, wraps modulo 256, and is not reduced by pops.
- R11: A push and a pop in the same cycle leave the count unchanged, even when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_lvl | input | 8 | Receive trigger in bits 3:0, transmit trigger in bits 7:4 |
| irq_en | input | 4 | Per-source enable, bit positions as in irq_stat |
| rx_clr | input | 1 | Pulse: empty the receive queue |
| tx_clr | input | 1 | Pulse: empty the transmit queue |
| stat_w1c | input | 4 | Write-1-to-clear for the done flags (bits 0 and 2) |
| cpu_wr | input | 1 | Processor pushes cpu_wdata into the transmit queue |
| cpu_wdata | input | 8 | Byte to transmit |
| cpu_rd | input | 1 | Processor pops the receive queue |
| cpu_rdata | output | 8 | Head of the receive queue, 0 when empty |
| eng_rx_push | input | 1 | Engine pushes eng_rx_data into the receive queue |
| eng_rx_data | input | 8 | Received byte |
| eng_tx_pop | input | 1 | Engine pops the transmit queue |
| eng_tx_data | output | 8 | Head of the transmit queue, 0 when empty |
| eng_tx_done | input | 1 | Strobe: frame sent |
| eng_rx_done | input | 1 | Strobe: frame received |
| fifo_cnt | output | 8 | Receive count in bits 3:0, transmit count in bits 7:4 |
| rx_len | output | 8 | Running count of accepted received bytes |
| ovf | output | 2 | Sticky overflow: bit 0 receive, bit 1 transmit |
| irq_stat | output | 4 | tx-done, tx-level, rx-done, rx-level in bits 0 to 3 |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The receive path is first run through a table of push-only, pop-only, simultaneous push-and-pop, and pop-on-empty cycles. This table separates correct head-of-queue ordering from count arithmetic, and shows the level bit rising and falling at a trigger of 3. The transmit path is filled past capacity and then drained. This exposes a dropped or accepted ninth byte, the overflow flag, and the moment the count falls to the trigger level. Done strobes are tested held, cleared, and cleared while a new strobe arrives. A run of 258 push-pop pairs after a clear shows whether the byte counter wraps, or whether pops wrongly reduce it.

// File: rtl/byte_fifo_irq.sv
module byte_fifo_irq #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] trig_lvl,
  input  logic [3:0] irq_en,
  input  logic       rx_clr,
  input  logic       tx_clr,
  input  logic [3:0] stat_w1c,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  input  logic       cpu_rd,
  output logic [7:0] cpu_rdata,
  input  logic       eng_rx_push,
  input  logic [7:0] eng_rx_data,
  input  logic       eng_tx_pop,
  output logic [7:0] eng_tx_data,
  input  logic       eng_tx_done,
  input  logic       eng_rx_done,
  output logic [7:0] fifo_cnt,
  output logic [7:0] rx_len,
  output logic [1:0] ovf,
  output logic [3:0] irq_stat,
  output logic       irq
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0]    rmem [DEPTH];
  logic [7:0]    tmem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [3:0]    rx_cnt, tx_cnt;
  logic [1:0]    done_q;

  wire rx_full  = rx_cnt == 4'(DEPTH);
  wire rx_empty = rx_cnt == 4'd0;
  wire tx_full  = tx_cnt == 4'(DEPTH);
  wire tx_empty = tx_cnt == 4'd0;

  wire rx_pop_ok  = cpu_rd && !rx_empty;
  wire rx_push_ok = eng_rx_push && (!rx_full || rx_pop_ok);
  wire tx_pop_ok  = eng_tx_pop && !tx_empty;
  wire tx_push_ok = cpu_wr && (!tx_full || tx_pop_ok);

  assign cpu_rdata   = rx_empty ? 8'h00 : rmem[rx_rp];
  assign eng_tx_data = tx_empty ? 8'h00 : tmem[tx_rp];
  assign fifo_cnt    = {tx_cnt, rx_cnt};

  always_ff @(posedge clk) begin
    if (rx_push_ok && !rx_clr) rmem[rx_wp] <= eng_rx_data;
    if (tx_push_ok && !tx_clr) tmem[tx_wp] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_len <= '0; ovf[0] <= 1'b0;
    end else if (rx_clr) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0; rx_len <= '0; ovf[0] <= 1'b0;
    end else begin
      if (rx_push_ok) begin
        rx_wp  <= rx_wp + 1'b1;
        rx_len <= rx_len + 8'd1;
      end
      if (rx_pop_ok) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + 4'(rx_push_ok) - 4'(rx_pop_ok);
      if (eng_rx_push && !rx_push_ok) ovf[0] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; ovf[1] <= 1'b0;
    end else if (tx_clr) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0; ovf[1] <= 1'b0;
    end else begin
      if (tx_push_ok) tx_wp <= tx_wp + 1'b1;
      if (tx_pop_ok)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + 4'(tx_push_ok) - 4'(tx_pop_ok);
      if (cpu_wr && !tx_push_ok) ovf[1] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 2'b00;
    else        done_q <= (done_q & ~{stat_w1c[2], stat_w1c[0]}) | {eng_rx_done, eng_tx_done};
  end

  assign irq_stat = {rx_cnt >= trig_lvl[3:0], done_q[1], tx_cnt <= trig_lvl[7:4], done_q[0]};
  assign irq      = |(irq_stat & irq_en);
endmodule

// File: rtl/byte_fifo_irq_chk.sv
module byte_fifo_irq_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_clr,
  input logic       tx_clr,
  input logic [3:0] stat_w1c,
  input logic       cpu_wr,
  input logic       cpu_rd,
  input logic       eng_rx_push,
  input logic       eng_tx_pop,
  input logic       eng_tx_done,
  input logic       eng_rx_done,
  input logic [7:0] fifo_cnt,
  input logic [7:0] rx_len,
  input logic [1:0] ovf,
  input logic [3:0] irq_stat
);
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt[3:0] <= 4'(DEPTH) && fifo_cnt[7:4] <= 4'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && !cpu_rd && !rx_clr && fifo_cnt[3:0] == 4'(DEPTH)
    |=> fifo_cnt[3:0] == 4'(DEPTH) && ovf[0]);

  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_pop && !cpu_wr && !tx_clr && fifo_cnt[7:4] == 4'd0 |=> fifo_cnt[7:4] == 4'd0);

  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_done |=> irq_stat[0]);

  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[2] && !stat_w1c[2] |=> irq_stat[2]);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> fifo_cnt[3:0] == 4'd0 && rx_len == 8'd0 && !ovf[0]);

  p_len_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && !rx_clr && fifo_cnt[3:0] < 4'(DEPTH) |=> rx_len == $past(rx_len) + 8'd1);

  p_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rx_push && cpu_rd && !rx_clr && fifo_cnt[3:0] != 4'd0 |=> $stable(fifo_cnt[3:0]));
endmodule

bind byte_fifo_irq byte_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_clr(rx_clr), .tx_clr(tx_clr), .stat_w1c(stat_w1c),
  .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .eng_rx_push(eng_rx_push), .eng_tx_pop(eng_tx_pop),
  .eng_tx_done(eng_tx_done), .eng_rx_done(eng_rx_done), .fifo_cnt(fifo_cnt),
  .rx_len(rx_len), .ovf(ovf), .irq_stat(irq_stat)
);

// File: tb/byte_fifo_irq_tb_top.sv
module byte_fifo_irq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] trig_lvl = 8'h23;
  logic [3:0] irq_en = 4'h0, stat_w1c = 4'h0;
  logic rx_clr = 0, tx_clr = 0, cpu_wr = 0, cpu_rd = 0, eng_rx_push = 0, eng_tx_pop = 0;
  logic eng_tx_done = 0, eng_rx_done = 0;
  logic [7:0] cpu_wdata = 0, eng_rx_data = 0;
  logic [7:0] cpu_rdata, eng_tx_data, fifo_cnt, rx_len;
  logic [1:0] ovf;
  logic [3:0] irq_stat;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  byte_fifo_irq dut_i (.*);

  // {push, pop, din, expected count, expected popped byte, expected rx-level bit}
  localparam logic [22:0] VEC [10] = '{
    {1'b1, 1'b0, 8'hA1, 4'd1, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'hB2, 4'd2, 8'h00, 1'b0},
    {1'b1, 1'b1, 8'hC3, 4'd2, 8'hA1, 1'b0},
    {1'b0, 1'b1, 8'h00, 4'd1, 8'hB2, 1'b0},
    {1'b0, 1'b1, 8'h00, 4'd0, 8'hC3, 1'b0},
    {1'b0, 1'b1, 8'h00, 4'd0, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h11, 4'd1, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h22, 4'd2, 8'h00, 1'b0},
    {1'b1, 1'b0, 8'h33, 4'd3, 8'h00, 1'b1},
    {1'b0, 1'b1, 8'h00, 4'd2, 8'h11, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
    cpu_wr = 0; cpu_rd = 0; eng_rx_push = 0; eng_tx_pop = 0; rx_clr = 0; tx_clr = 0;
    eng_tx_done = 0; eng_rx_done = 0; stat_w1c = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1 reset state, R5/R6 level bits with rx trigger 3, tx trigger 2
    chk("R1 cnt", fifo_cnt, 8'h00);
    chk("R1 ovf/len", {ovf, rx_len}, 10'h000);
    chk("R1 stat", irq_stat, 4'b0010);
    chk("R8 irq masked", irq, 1'b0);

    // R2 R4 R5 R11 table walk on the receive queue
    for (int i = 0; i < 10; i++) begin
      eng_rx_push = VEC[i][22]; cpu_rd = VEC[i][21]; eng_rx_data = VEC[i][20:13];
      #1;
      if (VEC[i][21]) chk($sformatf("R2/R4 rdata v%0d", i), cpu_rdata, VEC[i][8:1]);
      tick();
      chk($sformatf("R2/R11 rx cnt v%0d", i), fifo_cnt[3:0], VEC[i][12:9]);
      chk($sformatf("R5 rx lvl v%0d", i), irq_stat[3], VEC[i][0]);
    end

    // R9 clear beats push; rx_len reset
    rx_clr = 1; eng_rx_push = 1; eng_rx_data = 8'h99; tick();
    chk("R9 rx clr cnt", fifo_cnt[3:0], 4'd0);
    chk("R9 rx clr len", rx_len, 8'd0);
    chk("R4 empty rdata", cpu_rdata, 8'h00);

    // R3 R6 R2 transmit fill and overflow
    for (int i = 0; i < 8; i++) begin
      cpu_wr = 1; cpu_wdata = 8'h40 + 8'(i); tick();
    end
    chk("R2 tx cnt field", fifo_cnt, 8'h80);
    chk("R6 tx lvl low", irq_stat[1], 1'b0);
    cpu_wr = 1; cpu_wdata = 8'hFF; tick();
    chk("R3 tx cnt full", fifo_cnt[7:4], 4'd8);
    chk("R3 tx ovf", ovf, 2'b10);
    cpu_wr = 1; cpu_wdata = 8'h48; eng_tx_pop = 1; #1;
    chk("R11 tx head", eng_tx_data, 8'h40);
    tick();
    chk("R11 tx full push+pop", fifo_cnt[7:4], 4'd8);
    for (int i = 1; i < 7; i++) begin
      eng_tx_pop = 1; #1;
      chk("R2 tx order", eng_tx_data, 8'h40 + 8'(i));
      tick();
    end
    chk("R6 tx cnt 2", fifo_cnt[7:4], 4'd2);
    chk("R6 tx lvl high", irq_stat[1], 1'b1);
    irq_en = 4'b0010; #1;
    chk("R8 irq tx lvl", irq, 1'b1);
    eng_tx_pop = 1; #1;
    chk("R2 tx order 7", eng_tx_data, 8'h47);
    tick();
    eng_tx_pop = 1; #1;
    chk("R3 ninth dropped", eng_tx_data, 8'h48);
    tick();
    eng_tx_pop = 1; #1;
    chk("R4 tx empty data", eng_tx_data, 8'h00);
    tick();
    chk("R4 tx empty cnt", fifo_cnt[7:4], 4'd0);
    tx_clr = 1; tick();
    chk("R9 tx ovf cleared", ovf, 2'b00);

    // R3 receive overflow
    for (int i = 0; i < 9; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'(i); tick();
    end
    chk("R3 rx ovf", {ovf, fifo_cnt[3:0]}, {2'b01, 4'd8});
    chk("R10 len counts accepted", rx_len, 8'd8);
    rx_clr = 1; tick();

    // R7 R8 done flags
    irq_en = 4'b0000; eng_tx_done = 1; tick();
    chk("R7 tx done set", irq_stat[0], 1'b1);
    chk("R8 done masked", irq, 1'b0);
    tick(); tick();
    chk("R7 tx done sticky", irq_stat[0], 1'b1);
    irq_en = 4'b0001; #1;
    chk("R8 irq tx done", irq, 1'b1);
    stat_w1c = 4'b0001; tick();
    chk("R7 tx done w1c", irq_stat[0], 1'b0);
    eng_rx_done = 1; stat_w1c = 4'b0100; tick();
    chk("R7 set wins", irq_stat[2], 1'b1);
    irq_en = 4'b0100; #1;
    chk("R8 irq rx done", irq, 1'b1);
    stat_w1c = 4'b0100; tick();
    chk("R7 rx done w1c", irq_stat[2], 1'b0);

    // R10 wrap, pops do not reduce
    for (int i = 0; i < 258; i++) begin
      eng_rx_push = 1; tick();
      cpu_rd = 1; tick();
    end
    chk("R10 len wrap", rx_len, 8'd2);
    chk("R10 rx cnt", fifo_cnt[3:0], 4'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule